// File: doc/BRIEF.md
# Hit latency pipeline with run suppression

This block sits behind the per-channel discriminators of a multi-channel strip readout. On every clock edge it takes one binary sample per channel and pushes it into a delay line long enough to cover the level-1 trigger decision time. The default is 250 stages, about 4 µs at a 16 ns clock.

A discriminator pulse often spans several clocks. Before a sample is stored, the block keeps only the first '1' of each run of consecutive '1's on a channel and clears the rest. Each pulse therefore occupies a single pipeline slot.

When the trigger input is high at a clock edge, the block captures the word leaving the delay line and presents it in parallel, one bit per channel, to a downstream encoder. A one-cycle valid flag goes with the word. Outside those cycles the word output reads zero. The delay line keeps shifting every cycle, whether or not a trigger arrives.

Top module: `hit_latency_pipe`

## Requirements
- R1: While `rst_n` is low, `valid_o` is 0 and `word_o` is all zeros. Reset also clears every pipeline stage and the stored previous sample of each channel.
- R2: A channel's bit enters the pipeline as 1 only when its input is 1 at this edge and was 0 at the previous edge. The first edge after reset counts the previous input as 0.
- R3: A run of consecutive 1s of any length on a channel produces exactly one stored hit, placed at the run's first cycle.
- R4: When `trig_i` is high at edge n, `word_o` after that edge holds the stored value of the sample taken at edge n-DEPTH, with bit i belonging to channel i.
- R5: `valid_o` is 1 during the cycle after each edge at which `trig_i` was high, and 0 otherwise. Triggers on consecutive edges give consecutive valid cycles.
- R6: Whenever `valid_o` is 0, `word_o` is all zeros.
- R7: The delay line advances on every edge. Triggers, however dense, do not alter the stored samples or their timing.
- R8: A trigger within the first DEPTH edges after reset release captures an all-zero word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples and shifting happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release it synchronously to `clk` |
| disc_i | input | NCH | One discriminator output per channel |
| trig_i | input | 1 | Level-1 trigger, sampled on each rising edge |
| word_o | output | NCH | Captured channel word, one bit per channel; zero when not valid |
| valid_o | output | 1 | High for one cycle after each triggering edge |

## Verification
The bench builds the block with 4 channels and a depth of 6. With these values every pair of consecutive 4-bit input words (all 256) can be applied. Every trigger word can be compared with an arithmetic model that remembers each suppressed sample by cycle number. The short depth also puts the post-reset window of zero captures, long runs that outlast the whole pipeline, dense back-to-back triggers and a reset in mid-stream within a few thousand cycles.

// File: rtl/hitpipe_pkg.sv
package hitpipe_pkg;
  localparam int unsigned DEF_CHANNELS = 16;
  localparam int unsigned DEF_DEPTH    = 250;
  localparam int unsigned MIN_DEPTH    = 2;
endpackage

// File: rtl/hp_lead_edge.sv
module hp_lead_edge #(
  parameter int unsigned NCH = hitpipe_pkg::DEF_CHANNELS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw_i,
  output logic [NCH-1:0] lead_o
);
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] prev_d;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_comb begin
      prev_d[ch] = raw_i[ch];
      lead_o[ch] = raw_i[ch] & ~prev_q[ch];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/hp_delay_line.sv
module hp_delay_line #(
  parameter int unsigned NCH   = hitpipe_pkg::DEF_CHANNELS,
  parameter int unsigned DEPTH = hitpipe_pkg::DEF_DEPTH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din_i,
  output logic [NCH-1:0] head_o,
  output logic [NCH-1:0] second_o,
  output logic [NCH-1:0] tail_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [NCH-1:0] stage_q [DEPTH];
  logic [NCH-1:0] stage_d [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_comb stage_d[k] = din_i;
    end else begin : g_rest
      always_comb stage_d[k] = stage_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[k] <= '0;
      end else begin
        stage_q[k] <= stage_d[k];
      end
    end
  end

  assign head_o   = stage_q[0];
  assign second_o = stage_q[1];
  assign tail_o   = stage_q[LAST];
endmodule

// File: rtl/hp_trig_capture.sv
module hp_trig_capture #(
  parameter int unsigned NCH = hitpipe_pkg::DEF_CHANNELS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tail_i,
  input  logic           trig_i,
  output logic [NCH-1:0] word_o,
  output logic           valid_o
);
  logic [NCH-1:0] word_q, word_d;
  logic           valid_q, valid_d;
  logic           cap_en;

  always_comb begin
    cap_en  = trig_i | valid_q;
    valid_d = trig_i;
    word_d  = trig_i ? tail_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (cap_en) begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/hit_latency_pipe.sv
module hit_latency_pipe #(
  parameter int unsigned NCH   = hitpipe_pkg::DEF_CHANNELS,
  parameter int unsigned DEPTH = hitpipe_pkg::DEF_DEPTH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] disc_i,
  input  logic           trig_i,
  output logic [NCH-1:0] word_o,
  output logic           valid_o
);
  logic [NCH-1:0] lead_w;
  logic [NCH-1:0] head_w;
  logic [NCH-1:0] second_w;
  logic [NCH-1:0] tail_w;

  hp_lead_edge #(.NCH(NCH)) u_lead (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (disc_i),
    .lead_o (lead_w)
  );

  hp_delay_line #(.NCH(NCH), .DEPTH(DEPTH)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .din_i    (lead_w),
    .head_o   (head_w),
    .second_o (second_w),
    .tail_o   (tail_w)
  );

  hp_trig_capture #(.NCH(NCH)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .tail_i  (tail_w),
    .trig_i  (trig_i),
    .word_o  (word_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/hit_latency_pipe_chk.sv
module hit_latency_pipe_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig_i,
  input logic [NCH-1:0] word_o,
  input logic           valid_o,
  input logic [NCH-1:0] head,
  input logic [NCH-1:0] second
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!valid_o && word_o == '0)); // R1
  AST_NO_ADJ_STORE: assert property (@(posedge clk) disable iff (!rst_n) (head & second) == '0); // R2
  AST_NO_ADJ_WORDS: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && $past(valid_o)) |-> ((word_o & $past(word_o)) == '0)); // R3
  AST_TRIG_VALID: assert property (@(posedge clk) disable iff (!rst_n) trig_i |=> valid_o); // R5
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !trig_i |=> !valid_o); // R5
  AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> word_o == '0); // R6
endmodule

bind hit_latency_pipe hit_latency_pipe_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig_i  (trig_i),
  .word_o  (word_o),
  .valid_o (valid_o),
  .head    (head_w),
  .second  (second_w)
);

// File: tb/hit_latency_pipe_bench.sv
module hit_latency_pipe_bench;
  localparam int NCH   = 4;
  localparam int DEPTH = 6;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] disc_i;
  logic           trig_i;
  logic [NCH-1:0] word_o;
  logic           valid_o;

  int n_checks;
  int n_fail;
  int cyc;
  int ones_seen;
  bit done;
  logic [NCH-1:0] prev_m;
  logic [NCH-1:0] sup_hist [0:4095];

  hit_latency_pipe #(.NCH(NCH), .DEPTH(DEPTH)) u_hit_latency_pipe (
    .clk(clk), .rst_n(rst_n), .disc_i(disc_i), .trig_i(trig_i),
    .word_o(word_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // One clock: drive at negedge, model the edge, check at next negedge.
  task automatic step(input logic [NCH-1:0] din, input logic t, input string tag);
    logic [NCH-1:0] s;
    logic [NCH-1:0] exp;
    disc_i = din;
    trig_i = t;
    @(posedge clk);
    s = din & ~prev_m;
    sup_hist[cyc] = s;
    if (t && cyc >= DEPTH) exp = sup_hist[cyc-DEPTH];
    else exp = '0;
    prev_m = din;
    cyc++;
    @(negedge clk);
    check(valid_o == t, "R5 valid", int'(valid_o), int'(t));
    if (t) check(word_o == exp, {"R4 word ", tag}, int'(word_o), int'(exp));
    else check(word_o == '0, {"R6 idle ", tag}, int'(word_o), 0);
    if (valid_o) ones_seen += $countones(word_o);
  endtask

  task automatic do_reset(input logic [NCH-1:0] hold);
    @(negedge clk);
    disc_i = hold;
    trig_i = 1'b1;
    rst_n  = 1'b0;
    #1;
    check(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    check(word_o == '0, "R1 word in reset", int'(word_o), 0);
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && word_o == '0, "R1 held reset", int'(word_o), 0);
    trig_i = 1'b0;
    rst_n  = 1'b1;
    cyc    = 0;
    prev_m = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] lfsr;
    n_checks = 0; n_fail = 0; cyc = 0; ones_seen = 0; done = 1'b0;
    prev_m = '0;
    rst_n = 1'b0; disc_i = '0; trig_i = 1'b0;
    do_reset('1);

    // R8: triggers inside the first DEPTH edges capture zeros (input held high through reset)
    for (int i = 0; i < DEPTH; i++) step('1, 1'b1, "R8 early");
    for (int i = 0; i < DEPTH; i++) step('0, 1'b1, "R1 R2 leading after reset");

    // R2: every pair of consecutive input words, sparse triggers
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(NCH'(a), (cyc % 3) == 0, "R2 pair");
        step(NCH'(b), (cyc % 3) == 0, "R2 pair");
      end
    end
    for (int i = 0; i < DEPTH; i++) step('0, 1'b0, "flush");

    // R3: long run on all channels, dense triggers (R7)
    ones_seen = 0;
    for (int i = 0; i < 4*DEPTH; i++) step('1, 1'b1, "R3 R7 run");
    for (int i = 0; i < 2*DEPTH; i++) step('0, 1'b1, "R3 R7 tail");
    check(ones_seen == NCH, "R3 one hit per channel per run", ones_seen, NCH);

    // R3: staggered runs of different length per channel
    ones_seen = 0;
    for (int i = 0; i < 3*DEPTH; i++) begin
      logic [NCH-1:0] v;
      for (int ch = 0; ch < NCH; ch++) v[ch] = (i >= ch) && (i < ch + 2 + 3*ch);
      step(v, 1'b1, "R3 staggered");
    end
    for (int i = 0; i < DEPTH + 1; i++) step('0, 1'b1, "R3 staggered tail");
    check(ones_seen == NCH, "R3 staggered hit count", ones_seen, NCH);

    // R7: pseudo-random inputs and triggers
    lfsr = 8'hA5;
    for (int i = 0; i < 1200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[3:0], lfsr[6] ^ lfsr[1], "R7 random");
    end

    // R1: reset in mid-stream clears the pipeline and previous-sample memory
    for (int i = 0; i < DEPTH/2; i++) step(4'b1010, 1'b0, "pre-reset");
    do_reset(4'b1010);
    for (int i = 0; i < DEPTH; i++) step(4'b1010, 1'b1, "R1 R8 after mid reset");
    for (int i = 0; i < DEPTH; i++) step(4'b0000, 1'b1, "R1 R2 first sample leading");

    finish_run();
  end
endmodule